// File: doc/BRIEF.md
# Periodic Down-Counter Timer with Timestamp Counter

This block holds two counters behind a small word-addressed register bus. The first is a reload down-counter. It steps once for each tick strobe from the source that is selected, and raises an interrupt request when it underflows. The request stays latched until software writes to an acknowledge register. In periodic mode the counter reloads from its reload register on underflow. In free-run mode it wraps to all ones. A reload value of N therefore gives one interrupt every N+1 ticks.

The second counter is a 40-bit timestamp that counts up on its own tick strobe. It never interrupts. Software turns it on with the enable flag in its high read word, and reads the low 32 bits to measure elapsed ticks by wrapping subtraction.

The tick strobes are one-clock enables that come from outside the block. Bus writes take effect at the clock edge that samples them. Reads are combinational from the registers.

Top module: `tick_timer_unit`

## Requirements
- R1: After reset, every readable word reads 0 and `irq` is low.
- R2: Word 0 (reload) stores `bus_wdata[15:0]` and reads it back. While the timer is disabled, a reload write leaves word 1 (current count) unchanged.
- R3: A write to word 2 (control) that sets bit 7 (enable) while enable was clear copies the reload value into the count. While enabled, the count drops by one on each selected tick and holds without one.
- R4: With control bit 6 set (periodic), a selected tick at count 0 reloads the count from the reload register and sets `irq` on the next clock. `irq` rises only after such an underflow.
- R5: With control bit 6 clear (free-run), a selected tick at count 0 sets the count to 0xFFFF and still sets `irq`.
- R6: Control bit 3 set selects `tick_fast` as the count source; bit 3 clear selects `tick_slow`. The other strobe has no effect on the count.
- R7: Any write to word 3 (acknowledge) clears `irq` on the next clock, unless an underflow happens in the same cycle, in which case `irq` stays set.
- R8: A reload write while enabled also loads the count on the next clock. It takes priority over a tick in the same cycle, and that tick raises no interrupt.
- R9: While control bit 7 is clear, tick strobes leave the count unchanged.
- R10: The timestamp advances by one on each `tick_stamp` while its enable is set. Bit 8 of a write to word 5 sets that enable. Word 4 reads stamp bits 31:0. Word 5 reads stamp bits 39:32 in bits 7:0 and the enable in bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_fast | input | 1 | Fast count strobe, one clock wide |
| tick_slow | input | 1 | Slow count strobe, one clock wide |
| tick_stamp | input | 1 | Timestamp strobe, one clock wide |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Word address (0 reload, 1 count, 2 control, 3 acknowledge, 4 stamp low, 5 stamp high) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Latched underflow interrupt request |

## Verification
Every write and every tick strobe acts at the one rising edge that samples it. The count, the reload value, the stamp and `irq` all hold their new value from that edge on, and read data follows the registers with no extra delay. The bench therefore drives each stimulus for exactly one cycle starting at a falling edge, and reads results at the next falling edge, which is one register stage later. Cases where two events fall in the same cycle are driven inside that single cycle and checked at the following falling edge: acknowledge with underflow, and reload write with tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W  = 3;
  localparam int CTRL_W  = 8;
  localparam int EN_BIT  = 7;
  localparam int PER_BIT = 6;
  localparam int SRC_BIT = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_RELOAD   = 3'd0,
    A_COUNT    = 3'd1,
    A_CTRL     = 3'd2,
    A_ACK      = 3'd3,
    A_STAMP_LO = 3'd4,
    A_STAMP_HI = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/tmr_reload_ctr.sv
module tmr_reload_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             en_rise,
  input  logic             step,
  input  logic             periodic,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_data,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] count_q,
  output logic             underflow,
  output logic             load_upd
);
  // next count on a tick: decrement, or reload/wrap at zero
  function automatic logic [CNT_W-1:0] f_next(input logic [CNT_W-1:0] cur,
                                              input logic [CNT_W-1:0] rel,
                                              input logic per);
    if (cur == '0) return per ? rel : '1;
    return cur - 1'b1;
  endfunction

  assign load_upd  = load_wr & en;
  assign underflow = step & (count_q == '0) & ~load_upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= '0;
      count_q <= '0;
    end else begin
      if (load_wr) load_q <= load_data;
      if (load_upd)     count_q <= load_data;
      else if (en_rise) count_q <= load_q;
      else if (step)    count_q <= f_next(count_q, load_q, periodic);
    end
  end
endmodule

// File: rtl/tmr_irq_latch.sv
module tmr_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end
endmodule

// File: rtl/tmr_stamp_ctr.sv
module tmr_stamp_ctr #(
  parameter int STAMP_W = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr,
  input  logic               en_data,
  input  logic               tick,
  output logic               en_q,
  output logic [STAMP_W-1:0] stamp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      stamp_q <= '0;
    end else begin
      if (en_wr) en_q <= en_data;
      if (en_q && tick) stamp_q <= stamp_q + 1'b1;
    end
  end
endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit #(
  parameter int CNT_W   = 16,
  parameter int STAMP_W = 40,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick_fast,
  input  logic                       tick_slow,
  input  logic                       tick_stamp,
  input  logic                       bus_wr,
  input  logic [tmr_pkg::ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       irq
);
  import tmr_pkg::*;

  localparam int HI_W = STAMP_W - DATA_W;

  reg_addr_e          addr_e;
  logic               wr_reload, wr_ctrl, wr_ack, wr_hi;
  logic [CTRL_W-1:0]  ctrl_q;
  logic               en, periodic, en_rise, step;
  logic [CNT_W-1:0]   load_q, count_q;
  logic               underflow, load_upd;
  logic               stamp_en;
  logic [STAMP_W-1:0] stamp_q;

  assign addr_e    = reg_addr_e'(bus_addr);
  assign wr_reload = bus_wr && (addr_e == A_RELOAD);
  assign wr_ctrl   = bus_wr && (addr_e == A_CTRL);
  assign wr_ack    = bus_wr && (addr_e == A_ACK);
  assign wr_hi     = bus_wr && (addr_e == A_STAMP_HI);

  assign en       = ctrl_q[EN_BIT];
  assign periodic = ctrl_q[PER_BIT];
  assign en_rise  = wr_ctrl && bus_wdata[EN_BIT] && !en;
  assign step     = en && (ctrl_q[SRC_BIT] ? tick_fast : tick_slow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  tmr_reload_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .en_rise   (en_rise),
    .step      (step),
    .periodic  (periodic),
    .load_wr   (wr_reload),
    .load_data (bus_wdata[CNT_W-1:0]),
    .load_q    (load_q),
    .count_q   (count_q),
    .underflow (underflow),
    .load_upd  (load_upd)
  );

  tmr_irq_latch u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (underflow),
    .clr_i (wr_ack),
    .irq_q (irq)
  );

  tmr_stamp_ctr #(.STAMP_W(STAMP_W)) u_stamp (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_wr   (wr_hi),
    .en_data (bus_wdata[HI_W]),
    .tick    (tick_stamp),
    .en_q    (stamp_en),
    .stamp_q (stamp_q)
  );

  always_comb begin
    bus_rdata = '0;
    case (addr_e)
      A_RELOAD:   bus_rdata[CNT_W-1:0]  = load_q;
      A_COUNT:    bus_rdata[CNT_W-1:0]  = count_q;
      A_CTRL:     bus_rdata[CTRL_W-1:0] = ctrl_q;
      A_STAMP_LO: bus_rdata             = stamp_q[DATA_W-1:0];
      A_STAMP_HI: begin
        bus_rdata[HI_W-1:0] = stamp_q[STAMP_W-1:DATA_W];
        bus_rdata[HI_W]     = stamp_en;
      end
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W   = 16,
  parameter int STAMP_W = 40
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq,
  input logic               underflow,
  input logic               step,
  input logic               periodic,
  input logic               load_upd,
  input logic               en_rise,
  input logic               wr_ack,
  input logic [CNT_W-1:0]   load_q,
  input logic [CNT_W-1:0]   count_q,
  input logic               stamp_en,
  input logic               tick_stamp,
  input logic [STAMP_W-1:0] stamp_q
);
  AST_IRQ_ON_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> irq); // R4
  AST_IRQ_ONLY_AFTER_UF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(underflow)); // R4
  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && periodic) |=> count_q == $past(load_q)); // R4
  AST_FREERUN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !periodic) |=> count_q == {CNT_W{1'b1}}); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && !underflow) |=> !irq); // R7
  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_upd && !en_rise) |=> $stable(count_q)); // R9
  AST_STAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stamp_en && tick_stamp) |=> stamp_q == $past(stamp_q) + 1'b1); // R10
  AST_STAMP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(stamp_en && tick_stamp) |=> $stable(stamp_q)); // R10
endmodule

bind tick_timer_unit tmr_checker #(.CNT_W(CNT_W), .STAMP_W(STAMP_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq        (irq),
  .underflow  (underflow),
  .step       (step),
  .periodic   (periodic),
  .load_upd   (load_upd),
  .en_rise    (en_rise),
  .wr_ack     (wr_ack),
  .load_q     (load_q),
  .count_q    (count_q),
  .stamp_en   (stamp_en),
  .tick_stamp (tick_stamp),
  .stamp_q    (stamp_q)
);

// File: tb/tick_timer_unit_tb_top.sv
`timescale 1ns/1ps
module tick_timer_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_fast = 1'b0, tick_slow = 1'b0, tick_stamp = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  localparam logic [2:0] W_RELOAD = 3'd0, W_COUNT = 3'd1, W_CTRL = 3'd2,
                         W_ACK = 3'd3, W_LO = 3'd4, W_HI = 3'd5;

  always #5 clk = ~clk;

  tick_timer_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .tick_stamp(tick_stamp), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic f, input logic s, input logic t, input int n);
    for (int i = 0; i < n; i++) begin
      tick_fast = f; tick_slow = s; tick_stamp = t;
      @(negedge clk);
      tick_fast = 1'b0; tick_slow = 1'b0; tick_stamp = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R1 word reads zero", v, 32'd0);
    end
    check("R1 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_load_disabled();
    logic [31:0] v;
    wr(W_CTRL, 32'h48);
    wr(W_RELOAD, 32'h0001_0003);
    rd(W_RELOAD, v); check("R2 reload readback", v, 32'd3);
    rd(W_COUNT, v);  check("R2 count unchanged while disabled", v, 32'd0);
    pulse(1, 1, 0, 2);
    rd(W_COUNT, v);  check("R9 ticks ignored while disabled", v, 32'd0);
    check("R9 no irq while disabled", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    wr(W_CTRL, 32'hC8);
    rd(W_COUNT, v); check("R3 enable copies reload", v, 32'd3);
    pulse(1, 0, 0, 1);
    rd(W_COUNT, v); check("R3 decrement per tick", v, 32'd2);
    repeat (2) @(negedge clk);
    rd(W_COUNT, v); check("R3 hold without tick", v, 32'd2);
    pulse(1, 0, 0, 2);
    check("R4 no irq before N+1 ticks", {31'd0, irq}, 32'd0);
    pulse(1, 0, 0, 1);
    check("R4 irq after N+1 ticks", {31'd0, irq}, 32'd1);
    rd(W_COUNT, v); check("R4 reload on underflow", v, 32'd3);
  endtask

  task automatic t_ack();
    logic [31:0] v;
    wr(W_ACK, 32'h0);
    check("R7 acknowledge clears irq", {31'd0, irq}, 32'd0);
    pulse(1, 0, 0, 3);
    rd(W_COUNT, v); check("R7 setup count at zero", v, 32'd0);
    bus_wr = 1'b1; bus_addr = W_ACK; bus_wdata = 32'h0; tick_fast = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_fast = 1'b0;
    check("R7 underflow beats acknowledge", {31'd0, irq}, 32'd1);
    wr(W_ACK, 32'hFFFF_FFFF);
    check("R7 acknowledge any value", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_live_load();
    logic [31:0] v;
    pulse(1, 0, 0, 3);
    rd(W_COUNT, v); check("R8 setup count at zero", v, 32'd0);
    bus_wr = 1'b1; bus_addr = W_RELOAD; bus_wdata = 32'd9; tick_fast = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_fast = 1'b0;
    rd(W_COUNT, v); check("R8 live load beats tick", v, 32'd9);
    check("R8 no irq from masked tick", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_source();
    logic [31:0] v;
    wr(W_CTRL, 32'hC0);
    rd(W_COUNT, v); check("R6 no reload without enable edge", v, 32'd9);
    pulse(1, 0, 0, 2);
    rd(W_COUNT, v); check("R6 fast ignored when slow selected", v, 32'd9);
    pulse(0, 1, 0, 1);
    rd(W_COUNT, v); check("R6 slow strobe counts", v, 32'd8);
    wr(W_CTRL, 32'hC8);
    pulse(0, 1, 0, 2);
    rd(W_COUNT, v); check("R6 slow ignored when fast selected", v, 32'd8);
  endtask

  task automatic t_freerun();
    logic [31:0] v;
    wr(W_CTRL, 32'h08);
    wr(W_RELOAD, 32'd1);
    wr(W_ACK, 32'd0);
    wr(W_CTRL, 32'h88);
    rd(W_COUNT, v); check("R5 enable copies reload", v, 32'd1);
    pulse(1, 0, 0, 2);
    rd(W_COUNT, v); check("R5 wrap to all ones", v, 32'hFFFF);
    check("R5 irq in free-run", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_stamp();
    logic [31:0] v;
    pulse(0, 0, 1, 3);
    rd(W_LO, v); check("R10 stamp idle while disabled", v, 32'd0);
    wr(W_HI, 32'h100);
    pulse(0, 0, 1, 5);
    rd(W_LO, v); check("R10 stamp low counts", v, 32'd5);
    rd(W_HI, v); check("R10 high word enable flag", v, 32'h100);
    repeat (3) @(negedge clk);
    rd(W_LO, v); check("R10 stamp holds without tick", v, 32'd5);
    wr(W_HI, 32'h0);
    pulse(0, 0, 1, 2);
    rd(W_LO, v); check("R10 stamp stops when disabled", v, 32'd5);
    rd(W_HI, v); check("R10 high word after disable", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_disabled();
    t_periodic();
    t_ack();
    t_live_load();
    t_source();
    t_freerun();
    t_stamp();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule